// File: doc/BRIEF.md
# Request Packet Transaction Executor

This block sits behind a byte-stream deframer and turns each unescaped request packet into word accesses on a 32-bit memory-mapped master port. A packet opens with an 8-byte header that holds an operation code, a byte count and a start address. Write packets carry their data words after the header. The executor performs one bus access per word, advancing the address by four for sequential operations, and then emits a response packet on an outgoing byte stream that has its own start and end flags.

Reads come back as raw data with no header. Writes, and packets that make no bus access, are answered with a short 4-byte status header. Both byte streams use a valid/ready handshake. The bus side holds every access steady for as long as the slave raises its wait signal.

Top module: `pkt_txn_exec`

## Requirements
- R1: The header is 8 bytes in this order: opcode, one ignored byte, a 16-bit byte count sent high byte first, and a 32-bit address sent high byte first. A packet whose end flag arrives within its first 7 bytes produces no bus access and no response, and the block then accepts the next packet normally.
- R2: Opcode 0x00 writes one word to the header address. The data is taken from the 4 bytes after the header, least significant byte first. The response is the 4 bytes 0x80, 0x00, count high, count low, where count is the number of bytes written (0x0004).
- R3: Opcode 0x04 writes count/4 words to consecutive addresses that step by 4. Its response is 0x84, 0x00 and the written byte count sent high byte first.
- R4: Opcode 0x10 reads one word and answers with its 4 bytes, least significant first, with no header. The start flag is on the first response byte and the end flag on the last.
- R5: Opcode 0x14 reads count/4 words from addresses that step by 4 and answers with all of their bytes concatenated, each word least significant byte first.
- R6: The single opcodes 0x00 and 0x10 never access more than one word, even when the count field is larger.
- R7: Opcode 0x7F and any opcode not listed here make no bus access. They are answered with 4 bytes: opcode XOR 0x80, then three zero bytes.
- R8: While waitrequest is high, the asserted read or write strobe, the address and the write data stay unchanged. Each word is accessed exactly once.
- R9: While out_ready is low, a pending response byte and its flags stay unchanged.
- R10: Write data past count/4 words, and a trailing partial word, are discarded. The response count gives only the bytes actually written.
- R11: A read opcode with a count below 4 makes no bus access and is answered like R7 (0x90 or 0x94, then three zero bytes).
- R12: While idle, input bytes without the start flag are dropped and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Executor accepts a request byte |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | First byte of a request packet |
| in_eop | input | 1 | Last byte of a request packet |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Sink accepts a response byte |
| out_data | output | 8 | Response byte |
| out_sop | output | 1 | First byte of a response packet |
| out_eop | output | 1 | Last byte of a response packet |
| mm_read | output | 1 | Bus read strobe |
| mm_write | output | 1 | Bus write strobe |
| mm_addr | output | 32 | Bus byte address |
| mm_wdata | output | 32 | Bus write data |
| mm_rdata | input | 32 | Bus read data, valid in the cycle waitrequest is low |
| mm_waitreq | input | 1 | Slave stall |

## Verification
The bus checks assume that the slave delivers read data in the same cycle it drops waitrequest, and that waitrequest is never held high indefinitely. The stimulus slave model follows this: it grants every access after a fixed number of stall cycles, set per test to 0, 1 or 2. The output-hold check assumes the sink may drop out_ready at any time. One test therefore keeps out_ready low for two cycles out of three during a multi-word read, while the other tests keep it high. Request bytes are offered only through the valid/ready handshake, and each packet is fully sent before the next one starts.

// File: rtl/pkt_txn_pkg.sv
`timescale 1ns/1ps
package pkt_txn_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int SIZE_W     = 16;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int HDR_BYTES  = 8;
    localparam int WCNT_W     = SIZE_W - 2;
    localparam int HDR_CNT_W  = $clog2(HDR_BYTES + 1);
    localparam int IDX_W      = $clog2(WORD_BYTES);

    localparam logic [7:0] OP_WR     = 8'h00;
    localparam logic [7:0] OP_SEQ_WR = 8'h04;
    localparam logic [7:0] OP_RD     = 8'h10;
    localparam logic [7:0] OP_SEQ_RD = 8'h14;
    localparam logic [7:0] RESP_FLIP = 8'h80;

    typedef struct packed {
        logic [7:0]        op;
        logic [WCNT_W-1:0] wcount;
        logic [ADDR_W-1:0] addr;
    } req_hdr_t;

    typedef enum logic [1:0] {
        KIND_WR,
        KIND_RD,
        KIND_NONE
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  seq;
    } op_info_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_DECIDE,
        ST_WDATA,
        ST_WBUS,
        ST_DRAIN,
        ST_RBUS,
        ST_RSEND,
        ST_RESP_LD,
        ST_RESP
    } exec_st_e;

    function automatic op_info_t decode_op(input logic [7:0] op);
        op_info_t info;
        case (op)
            OP_WR:     info = '{kind: KIND_WR,   seq: 1'b0};
            OP_SEQ_WR: info = '{kind: KIND_WR,   seq: 1'b1};
            OP_RD:     info = '{kind: KIND_RD,   seq: 1'b0};
            OP_SEQ_RD: info = '{kind: KIND_RD,   seq: 1'b1};
            default:   info = '{kind: KIND_NONE, seq: 1'b0};
        endcase
        return info;
    endfunction

    function automatic logic [WCNT_W-1:0] word_limit(input op_info_t info,
                                                     input logic [WCNT_W-1:0] words);
        if (!info.seq && words > WCNT_W'(1))
            return WCNT_W'(1);
        return words;
    endfunction

    // Status word, emitted least significant byte first on the wire.
    function automatic logic [DATA_W-1:0] status_word(input logic [7:0] op,
                                                      input logic [SIZE_W-1:0] nbytes);
        return {nbytes[7:0], nbytes[15:8], 8'h00, op ^ RESP_FLIP};
    endfunction

endpackage

// File: rtl/txn_hdr_collect.sv
`timescale 1ns/1ps
module txn_hdr_collect
    import pkt_txn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 first,
    input  logic [7:0]           byte_in,
    output req_hdr_t             hdr,
    output logic [HDR_CNT_W-1:0] cnt
);

    int pos;
    always_comb pos = first ? 0 : int'(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr <= '0;
            cnt <= '0;
        end else if (take) begin
            cnt <= first ? HDR_CNT_W'(1) : cnt + HDR_CNT_W'(1);
            case (pos)
                0: hdr.op <= byte_in;
                1: ;
                2: hdr.wcount[WCNT_W-1:6] <= byte_in;
                3: hdr.wcount[5:0] <= byte_in[7:2];
                default: hdr.addr[8*(HDR_BYTES-1-pos) +: 8] <= byte_in;
            endcase
        end
    end

    AST_HDR_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= HDR_CNT_W'(HDR_BYTES)) else $error("header count overrun"); // R1

endmodule

// File: rtl/txn_word_pack.sv
`timescale 1ns/1ps
module txn_word_pack
    import pkt_txn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic [DATA_W-1:0] word,
    output logic              last_byte
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES - 1);

    logic [IDX_W-1:0] cnt;

    assign last_byte = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            cnt  <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (take) begin
            word <= {byte_in, word[DATA_W-1:8]};
            cnt  <= cnt + IDX_W'(1);
        end
    end

endmodule

// File: rtl/txn_byte_ser.sv
`timescale 1ns/1ps
module txn_byte_ser
    import pkt_txn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] word_in,
    input  logic              sop_in,
    input  logic              eop_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              fin
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES - 1);

    logic [DATA_W-1:0] sh;
    logic [IDX_W-1:0]  idx;
    logic              sop_f, eop_f, active;

    assign out_valid = active;
    assign out_data  = sh[7:0];
    assign out_sop   = sop_f && (idx == '0);
    assign out_eop   = eop_f && (idx == LAST);
    assign fin       = active && out_ready && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            idx    <= '0;
            sop_f  <= 1'b0;
            eop_f  <= 1'b0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= word_in;
            idx    <= '0;
            sop_f  <= sop_in;
            eop_f  <= eop_in;
            active <= 1'b1;
        end else if (active && out_ready) begin
            if (idx == LAST) begin
                active <= 1'b0;
            end else begin
                sh  <= sh >> 8;
                idx <= idx + IDX_W'(1);
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))
        else $error("response byte changed under backpressure"); // R9

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !active) else $error("serializer reloaded while busy"); // R4

    AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_eop |=> !out_valid) else $error("bytes after end flag"); // R4

endmodule

// File: rtl/pkt_txn_exec.sv
`timescale 1ns/1ps
module pkt_txn_exec
    import pkt_txn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              mm_read,
    output logic              mm_write,
    output logic [ADDR_W-1:0] mm_addr,
    output logic [DATA_W-1:0] mm_wdata,
    input  logic [DATA_W-1:0] mm_rdata,
    input  logic              mm_waitreq
);

    exec_st_e             state;
    req_hdr_t             hdr;
    logic [HDR_CNT_W-1:0] hdr_cnt;
    logic                 hdr_eop, wr_eop, pend_read, first_word;
    logic [ADDR_W-1:0]    addr_q;
    logic [WCNT_W-1:0]    words_left;
    logic [SIZE_W-1:0]    wr_bytes;

    logic                 take, hdr_take, hdr_first, pack_take, pack_clear, pack_last;
    logic [DATA_W-1:0]    pack_word;
    logic                 ser_load, ser_sop, ser_eop, ser_fin;
    logic [DATA_W-1:0]    ser_word;
    op_info_t             info;
    logic [WCNT_W-1:0]    lim;
    logic                 grant;

    assign in_ready = (state == ST_IDLE) || (state == ST_HDR) ||
                      (state == ST_WDATA) || (state == ST_DRAIN);
    assign take       = in_valid && in_ready;
    assign hdr_first  = (state == ST_IDLE);
    assign hdr_take   = take && ((state == ST_IDLE && in_sop) || state == ST_HDR);
    assign pack_take  = take && (state == ST_WDATA);
    assign pack_clear = (state == ST_DECIDE);
    assign info       = decode_op(hdr.op);
    assign lim        = word_limit(info, hdr.wcount);
    assign grant      = !mm_waitreq;

    assign mm_read  = (state == ST_RBUS);
    assign mm_write = (state == ST_WBUS);
    assign mm_addr  = addr_q;
    assign mm_wdata = pack_word;

    assign ser_load = (state == ST_RESP_LD) || (state == ST_RBUS && grant);
    assign ser_word = (state == ST_RESP_LD) ? status_word(hdr.op, wr_bytes) : mm_rdata;
    assign ser_sop  = (state == ST_RESP_LD) ? 1'b1 : first_word;
    assign ser_eop  = (state == ST_RESP_LD) ? 1'b1 : (words_left == WCNT_W'(1));

    txn_hdr_collect u_hdr (
        .clk     (clk),
        .rst     (rst),
        .take    (hdr_take),
        .first   (hdr_first),
        .byte_in (in_data),
        .hdr     (hdr),
        .cnt     (hdr_cnt)
    );

    txn_word_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .clear     (pack_clear),
        .take      (pack_take),
        .byte_in   (in_data),
        .word      (pack_word),
        .last_byte (pack_last)
    );

    txn_byte_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (ser_load),
        .word_in   (ser_word),
        .sop_in    (ser_sop),
        .eop_in    (ser_eop),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .fin       (ser_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            hdr_eop    <= 1'b0;
            wr_eop     <= 1'b0;
            pend_read  <= 1'b0;
            first_word <= 1'b0;
            addr_q     <= '0;
            words_left <= '0;
            wr_bytes   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take && in_sop && !in_eop)
                        state <= ST_HDR;
                end
                ST_HDR: begin
                    if (take) begin
                        if (hdr_cnt == HDR_CNT_W'(HDR_BYTES - 1)) begin
                            hdr_eop <= in_eop;
                            state   <= ST_DECIDE;
                        end else if (in_eop) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DECIDE: begin
                    addr_q     <= hdr.addr;
                    words_left <= lim;
                    wr_bytes   <= '0;
                    first_word <= 1'b1;
                    pend_read  <= (info.kind == KIND_RD) && (lim != '0);
                    if (info.kind == KIND_RD && lim != '0)
                        state <= hdr_eop ? ST_RBUS : ST_DRAIN;
                    else if (hdr_eop)
                        state <= ST_RESP_LD;
                    else if (info.kind == KIND_WR && lim != '0)
                        state <= ST_WDATA;
                    else
                        state <= ST_DRAIN;
                end
                ST_WDATA: begin
                    if (take) begin
                        if (pack_last) begin
                            wr_eop <= in_eop;
                            state  <= ST_WBUS;
                        end else if (in_eop) begin
                            state <= ST_RESP_LD;
                        end
                    end
                end
                ST_WBUS: begin
                    if (grant) begin
                        wr_bytes   <= wr_bytes + SIZE_W'(WORD_BYTES);
                        addr_q     <= addr_q + ADDR_W'(WORD_BYTES);
                        words_left <= words_left - WCNT_W'(1);
                        if (wr_eop)
                            state <= ST_RESP_LD;
                        else if (words_left == WCNT_W'(1))
                            state <= ST_DRAIN;
                        else
                            state <= ST_WDATA;
                    end
                end
                ST_DRAIN: begin
                    if (take && in_eop)
                        state <= pend_read ? ST_RBUS : ST_RESP_LD;
                end
                ST_RBUS: begin
                    if (grant) begin
                        first_word <= 1'b0;
                        state      <= ST_RSEND;
                    end
                end
                ST_RSEND: begin
                    if (ser_fin) begin
                        if (words_left == WCNT_W'(1)) begin
                            state <= ST_IDLE;
                        end else begin
                            addr_q     <= addr_q + ADDR_W'(WORD_BYTES);
                            words_left <= words_left - WCNT_W'(1);
                            state      <= ST_RBUS;
                        end
                    end
                end
                ST_RESP_LD: state <= ST_RESP;
                ST_RESP: begin
                    if (ser_fin)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mm_read || mm_write) && mm_waitreq |=>
            mm_read == $past(mm_read) && mm_write == $past(mm_write) &&
            $stable(mm_addr) && $stable(mm_wdata))
        else $error("bus access changed while stalled"); // R8

    AST_WRITE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        mm_write |-> !out_valid) else $error("response overlaps a write"); // R2

endmodule

// File: tb/pkt_txn_exec_bench.sv
`timescale 1ns/1ps
module pkt_txn_exec_bench;
    import pkt_txn_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_sop, out_eop;
    logic        mm_read, mm_write;
    logic [31:0] mm_addr, mm_wdata;
    logic [31:0] mm_rdata = '0;
    logic        mm_waitreq = 1'b0;

    always #2.5 clk = ~clk;

    pkt_txn_exec u_pkt_txn_exec (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop),
        .mm_read(mm_read), .mm_write(mm_write), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_waitreq(mm_waitreq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // slave model
    logic [31:0] mem [16];
    int          wait_cfg = 0;
    int          wcnt = 0;
    logic [31:0] wlog_a[$];
    logic [31:0] wlog_d[$];
    int          rd_cnt = 0;

    always @(negedge clk) begin
        if (!rst && (mm_read || mm_write)) begin
            if (wcnt < wait_cfg) begin
                mm_waitreq = 1'b1;
                wcnt++;
            end else begin
                mm_waitreq = 1'b0;
                wcnt = 0;
                if (mm_write) begin
                    mem[mm_addr[5:2]] = mm_wdata;
                    wlog_a.push_back(mm_addr);
                    wlog_d.push_back(mm_wdata);
                end else begin
                    mm_rdata = mem[mm_addr[5:2]];
                    rd_cnt++;
                end
            end
        end else begin
            mm_waitreq = 1'b0;
            wcnt = 0;
        end
    end

    // response monitor
    logic [7:0] rsp_q[$];
    logic       sop_q[$];
    logic       eop_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] pkt[$];
    int         cyc = 0;
    bit         bp_on = 0;
    bit         prev_stall = 0;
    logic [7:0] prev_data = '0;
    int         hold_err = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            out_ready = 1'b1;
            prev_stall = 0;
        end else begin
            if (prev_stall && out_valid && out_data !== prev_data) hold_err++;
            out_ready = bp_on ? (cyc % 3 == 0) : 1'b1;
            if (out_valid && out_ready) begin
                rsp_q.push_back(out_data);
                sop_q.push_back(out_sop);
                eop_q.push_back(out_eop);
            end
            prev_stall = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic begin_test();
        rsp_q.delete(); sop_q.delete(); eop_q.delete();
        exp_q.delete(); pkt.delete();
        wlog_a.delete(); wlog_d.delete();
        rd_cnt = 0;
    endtask

    task automatic add_hdr(input logic [7:0] op, input logic [15:0] sz, input logic [31:0] a);
        pkt.push_back(op); pkt.push_back(8'h00);
        pkt.push_back(sz[15:8]); pkt.push_back(sz[7:0]);
        pkt.push_back(a[31:24]); pkt.push_back(a[23:16]);
        pkt.push_back(a[15:8]); pkt.push_back(a[7:0]);
    endtask

    task automatic add_word(input logic [31:0] w);
        pkt.push_back(w[7:0]); pkt.push_back(w[15:8]);
        pkt.push_back(w[23:16]); pkt.push_back(w[31:24]);
    endtask

    task automatic exp_bytes(input logic [7:0] b0, b1, b2, b3);
        exp_q.push_back(b0); exp_q.push_back(b1);
        exp_q.push_back(b2); exp_q.push_back(b3);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sop = s; in_eop = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_pkt();
        for (int i = 0; i < pkt.size(); i++)
            send_byte(pkt[i], i == 0, i == pkt.size() - 1);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic wait_rsp(input int n);
        for (int i = 0; i < 3000 && rsp_q.size() < n; i++) @(posedge clk);
        repeat (20) @(posedge clk);
    endtask

    task automatic chk_rsp(input string tag);
        int ns, ne;
        chk({tag, " response length"}, rsp_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rsp_q.size(); i++)
            chk($sformatf("%s response byte %0d", tag, i), rsp_q[i], exp_q[i]);
        if (exp_q.size() > 0 && rsp_q.size() > 0) begin
            ns = 0; ne = 0;
            for (int i = 0; i < sop_q.size(); i++) begin
                ns += int'(sop_q[i]);
                ne += int'(eop_q[i]);
            end
            chk({tag, " start flag on first byte"}, sop_q[0], 1'b1);
            chk({tag, " end flag on last byte"}, eop_q[eop_q.size()-1], 1'b1);
            chk({tag, " one start flag"}, ns, 1);
            chk({tag, " one end flag"}, ne, 1);
        end
    endtask

    task automatic t_reset();
        chk("reset out_valid", out_valid, 0);
        chk("reset mm_read", mm_read, 0);
        chk("reset mm_write", mm_write, 0);
        chk("R12 reset in_ready", in_ready, 1);
    endtask

    task automatic t_single_write();
        begin_test(); wait_cfg = 0;
        add_hdr(8'h00, 16'd4, 32'h10); add_word(32'h12345678);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h80, 8'h00, 8'h00, 8'h04);
        chk_rsp("R2");
        chk("R2 write count", wlog_a.size(), 1);
        if (wlog_a.size() == 1) begin
            chk("R2 write addr", wlog_a[0], 32'h10);
            chk("R2 write data", wlog_d[0], 32'h12345678);
        end
    endtask

    task automatic t_seq_write_wait();
        logic [31:0] w[3] = '{32'h11223344, 32'h55667788, 32'h99AABBCC};
        begin_test(); wait_cfg = 2;
        add_hdr(8'h04, 16'd12, 32'h20);
        for (int i = 0; i < 3; i++) add_word(w[i]);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h84, 8'h00, 8'h00, 8'h0C);
        chk_rsp("R3");
        chk("R8 each write once", wlog_a.size(), 3);
        for (int i = 0; i < 3 && i < wlog_a.size(); i++) begin
            chk("R3 write addr step", wlog_a[i], 32'h20 + 32'(4 * i));
            chk("R3 write data", wlog_d[i], w[i]);
        end
        wait_cfg = 0;
    endtask

    task automatic t_single_read();
        begin_test(); wait_cfg = 0;
        add_hdr(8'h10, 16'd4, 32'h04);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h01, 8'hC0, 8'hB0, 8'hA0);
        chk_rsp("R4");
        chk("R4 read count", rd_cnt, 1);
    endtask

    task automatic t_seq_read_bp();
        begin_test(); wait_cfg = 1; bp_on = 1; hold_err = 0;
        add_hdr(8'h14, 16'd12, 32'h20);
        send_pkt(); wait_rsp(12);
        exp_bytes(8'h44, 8'h33, 8'h22, 8'h11);
        exp_bytes(8'h88, 8'h77, 8'h66, 8'h55);
        exp_bytes(8'hCC, 8'hBB, 8'hAA, 8'h99);
        chk_rsp("R5");
        chk("R8 each read once", rd_cnt, 3);
        chk("R9 byte held under backpressure", hold_err, 0);
        bp_on = 0; wait_cfg = 0;
    endtask

    task automatic t_single_oversize();
        begin_test();
        add_hdr(8'h00, 16'd8, 32'h30);
        add_word(32'hCAFE0001); add_word(32'hCAFE0002);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h80, 8'h00, 8'h00, 8'h04);
        chk_rsp("R6 R10");
        chk("R6 single write one word", wlog_a.size(), 1);
        if (wlog_a.size() > 0) chk("R6 write data", wlog_d[0], 32'hCAFE0001);
        begin_test();
        add_hdr(8'h10, 16'd8, 32'h30);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h01, 8'h00, 8'hFE, 8'hCA);
        chk_rsp("R6 read");
        chk("R6 single read one word", rd_cnt, 1);
    endtask

    task automatic t_no_trans();
        begin_test();
        add_hdr(8'h7F, 16'd4, 32'h00);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'hFF, 8'h00, 8'h00, 8'h00);
        chk_rsp("R7 nop");
        begin_test();
        add_hdr(8'h33, 16'd4, 32'h08); pkt.push_back(8'h5A); pkt.push_back(8'hA5);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'hB3, 8'h00, 8'h00, 8'h00);
        chk_rsp("R7 unknown");
        chk("R7 no bus write", wlog_a.size(), 0);
        chk("R7 no bus read", rd_cnt, 0);
    endtask

    task automatic t_truncated();
        begin_test();
        pkt.push_back(8'h00); pkt.push_back(8'h00); pkt.push_back(8'h00);
        send_pkt(); wait_rsp(1);
        chk("R1 truncated no response", rsp_q.size(), 0);
        chk("R1 truncated no write", wlog_a.size(), 0);
        begin_test();
        add_hdr(8'h10, 16'd4, 32'h10);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h78, 8'h56, 8'h34, 8'h12);
        chk_rsp("R1 recovery");
    endtask

    task automatic t_short_data();
        begin_test();
        add_hdr(8'h04, 16'd8, 32'h38);
        add_word(32'hBEEF0010); pkt.push_back(8'h77); pkt.push_back(8'h66);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h84, 8'h00, 8'h00, 8'h04);
        chk_rsp("R10");
        chk("R10 partial word dropped", wlog_a.size(), 1);
    endtask

    task automatic t_zero_read();
        begin_test();
        add_hdr(8'h10, 16'd2, 32'h00);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'h90, 8'h00, 8'h00, 8'h00);
        chk_rsp("R11");
        chk("R11 no bus read", rd_cnt, 0);
    endtask

    task automatic t_stray();
        begin_test();
        send_byte(8'h04, 1'b0, 1'b0);
        send_byte(8'h00, 1'b0, 1'b0);
        send_byte(8'h00, 1'b0, 1'b1);
        @(negedge clk); in_valid = 1'b0; in_eop = 1'b0;
        wait_rsp(1);
        chk("R12 stray no response", rsp_q.size(), 0);
        chk("R12 stray no write", wlog_a.size(), 0);
        add_hdr(8'h7F, 16'd0, 32'h00);
        send_pkt(); wait_rsp(4);
        exp_bytes(8'hFF, 8'h00, 8'h00, 8'h00);
        chk_rsp("R12 next packet");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA0B0C000 | 32'(i);
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_write();
        t_seq_write_wait();
        t_single_read();
        t_seq_read_bp();
        t_single_oversize();
        t_no_trans();
        t_truncated();
        t_short_data();
        t_zero_read();
        t_stray();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule